// File: doc/BRIEF.md
# Age-Ordered Reservation Station

This block is a small scheduling queue placed in front of a single execution port. An upstream rename stage hands it micro-ops in program order over a valid/ready handshake. Each micro-op carries two source physical-register tags, each with its own ready bit, plus a destination tag and an opaque payload. The queue holds each micro-op until both of its sources are available. It then sends micro-ops to the port one per cycle, oldest ready first.

The block listens to a result-broadcast bus, which carries a valid bit and a tag. A source whose tag matches a broadcast becomes ready, and this includes a micro-op that arrives in the same cycle as the broadcast. Relative age is kept in an age matrix. Because of this, the issue choice stays exact however entries leave, and a blocked older entry never holds back a younger ready one. When every slot is taken, the queue drops its input ready, which stalls the shared upstream path. A synchronous flush empties the whole queue. The depth is a parameter: 8 for arithmetic ports, 6 for a memory port.

Top module: `rs_sched`

## Requirements
- R1: While reset is applied and afterwards until the first accepted micro-op, `iss_valid` is 0 and `in_ready` is 1.
- R2: A micro-op offered with `in_valid` while `in_ready` is 1 and `flush` is 0 is accepted at that clock edge, at most one per cycle. It is never issued in the cycle it is offered, and it can be issued in the next cycle at the earliest.
- R3: `in_ready` is 0 exactly when all DEPTH slots are occupied. A micro-op offered while `in_ready` is 0 is dropped and never issued.
- R4: Among resident entries whose two sources are both ready, the one accepted earliest is issued.
- R5: An older entry with an unready source does not block a younger ready entry, and it stays resident.
- R6: When no resident entry has both sources ready, `iss_valid` is 0.
- R7: A broadcast with `wb_valid`=1 whose `wb_tag` equals a waiting source tag marks that source ready at that edge. The entry becomes eligible for issue in the next cycle.
- R8: A micro-op whose source tag equals the `wb_tag` of a valid broadcast in its arrival cycle is stored with that source ready.
- R9: An issued entry leaves the queue at the edge that ends its issue cycle. If the queue was full, `in_ready` is 1 in the following cycle.
- R10: `flush`=1 empties the queue at that edge. A micro-op offered in the same cycle is dropped. In the next cycle `iss_valid`=0 and `in_ready`=1, and later broadcasts revive nothing.
- R11: At most one micro-op is issued per cycle. `iss_dst_tag` and `iss_payload` are the values that the issued micro-op was accepted with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Synchronous clear of all entries |
| in_valid | input | 1 | Upstream offers a micro-op |
| in_ready | output | 1 | A slot is free |
| in_src1_tag | input | TAG_W | First source tag |
| in_src1_rdy | input | 1 | First source already available |
| in_src2_tag | input | TAG_W | Second source tag |
| in_src2_rdy | input | 1 | Second source already available |
| in_dst_tag | input | TAG_W | Destination tag |
| in_payload | input | PAY_W | Opaque micro-op payload |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Tag of the broadcast result |
| iss_valid | output | 1 | A micro-op is issued this cycle |
| iss_dst_tag | output | TAG_W | Destination tag of the issued micro-op |
| iss_payload | output | PAY_W | Payload of the issued micro-op |

## Verification
The hardest case to reach from the ports is a full window in which the older entries stay blocked while younger ones wake up, so that the selection has to skip over stale age relations left behind by slots that were freed and refilled out of order. The stimulus produces this in two ways. Directed sequences fill the queue behind one unresolved tag and then release tags one at a time. Long random runs use a small tag space, sparse broadcasts and rare flushes, which keep the queue near full while slots turn over in scattered order. A reference model in the bench, ordered by sequence number, predicts every issue.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RS_DEPTH_DEF = 8;
  localparam int unsigned RS_TAG_W_DEF = 6;
  localparam int unsigned RS_PAY_W_DEF = 16;
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int unsigned DEPTH = 8
) (
  input  logic [DEPTH-1:0] vld,
  output logic [DEPTH-1:0] free_oh,
  output logic             has_free
);
  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
    has_free = found;
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             clr,
  input  logic [TAG_W-1:0] in_t1,
  input  logic             in_r1,
  input  logic [TAG_W-1:0] in_t2,
  input  logic             in_r2,
  input  logic [TAG_W-1:0] in_dst,
  input  logic [PAY_W-1:0] in_pay,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             vld,
  output logic             both_rdy,
  output logic [TAG_W-1:0] dst,
  output logic [PAY_W-1:0] pay
);
  logic             vld_q, vld_d;
  logic             r1_q, r1_d, r2_q, r2_d;
  logic [TAG_W-1:0] t1_q, t2_q, dst_q;
  logic [PAY_W-1:0] pay_q;

  // next state: wake-up on stored tags, or load with wake-up on incoming tags
  always_comb begin
    vld_d = vld_q;
    r1_d  = r1_q | (wb_valid && (t1_q == wb_tag));
    r2_d  = r2_q | (wb_valid && (t2_q == wb_tag));
    if (wr) begin
      vld_d = 1'b1;
      r1_d  = in_r1 | (wb_valid && (in_t1 == wb_tag));
      r2_d  = in_r2 | (wb_valid && (in_t2 == wb_tag));
    end
    if (clr) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      r1_q  <= 1'b0;
      r2_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      r1_q  <= r1_d;
      r2_q  <= r2_d;
    end
  end

  // data fields: load enable only, no reset
  always_ff @(posedge clk) begin
    if (wr) begin
      t1_q  <= in_t1;
      t2_q  <= in_t2;
      dst_q <= in_dst;
      pay_q <= in_pay;
    end
  end

  assign vld      = vld_q;
  assign both_rdy = vld_q & r1_q & r2_q;
  assign dst      = dst_q;
  assign pay      = pay_q;
endmodule

// File: rtl/rs_age_matrix.sv
module rs_age_matrix #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] alloc_oh,
  input  logic [DEPTH-1:0] req,
  output logic [DEPTH-1:0] grant
);
  // older_q[i][j] = 1 : entry i was written before entry j
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] older_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      older_d[i] = older_q[i] | alloc_oh;           // every slot is older than a newcomer
      if (alloc_oh[i]) older_d[i] = '0;            // newcomer is older than nobody
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else if (|alloc_oh) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= older_d[i];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++) blocked = blocked | (req[j] & older_q[j][i]);
      grant[i] = req[i] & ~blocked;
    end
  end
endmodule

// File: rtl/rs_sched.sv
module rs_sched
  import rs_pkg::*;
#(
  parameter int unsigned DEPTH = RS_DEPTH_DEF,
  parameter int unsigned TAG_W = RS_TAG_W_DEF,
  parameter int unsigned PAY_W = RS_PAY_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_src1_tag,
  input  logic             in_src1_rdy,
  input  logic [TAG_W-1:0] in_src2_tag,
  input  logic             in_src2_rdy,
  input  logic [TAG_W-1:0] in_dst_tag,
  input  logic [PAY_W-1:0] in_payload,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             iss_valid,
  output logic [TAG_W-1:0] iss_dst_tag,
  output logic [PAY_W-1:0] iss_payload
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [DEPTH-1:0] vld, rdy_vec, free_oh, wr_oh, grant;
  logic             has_free, accept;
  logic [TAG_W-1:0] ent_dst [DEPTH];
  logic [PAY_W-1:0] ent_pay [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  rs_alloc #(.DEPTH(DEPTH)) u_alloc (.vld(vld), .free_oh(free_oh), .has_free(has_free));

  assign in_ready = has_free;
  assign accept   = in_valid & has_free & ~flush;
  assign wr_oh    = free_oh & {DEPTH{accept}};

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    rs_entry #(.TAG_W(TAG_W), .PAY_W(PAY_W)) u_ent (
      .clk(clk), .rst_n(rst_n_s), .wr(wr_oh[g]), .clr(flush | grant[g]),
      .in_t1(in_src1_tag), .in_r1(in_src1_rdy), .in_t2(in_src2_tag), .in_r2(in_src2_rdy),
      .in_dst(in_dst_tag), .in_pay(in_payload), .wb_valid(wb_valid), .wb_tag(wb_tag),
      .vld(vld[g]), .both_rdy(rdy_vec[g]), .dst(ent_dst[g]), .pay(ent_pay[g])
    );
  end

  rs_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst_n(rst_n_s), .alloc_oh(wr_oh), .req(rdy_vec), .grant(grant)
  );

  always_comb begin
    iss_dst_tag = '0;
    iss_payload = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) begin
        iss_dst_tag = iss_dst_tag | ent_dst[i];
        iss_payload = iss_payload | ent_pay[i];
      end
    end
  end
  assign iss_valid = |grant;
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
  parameter int unsigned DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic             iss_valid,
  input logic [DEPTH-1:0] vld,
  input logic [DEPTH-1:0] rdy_vec,
  input logic [DEPTH-1:0] grant,
  input logic [DEPTH-1:0] wr_oh
);
  // R11
  one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n_s) $onehot0(grant));
  // R6
  idle_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rdy_vec == '0) |-> !iss_valid);
  // R3
  no_accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!in_ready && !flush) |=> ($countones(vld) <= $past($countones(vld))));
  // R2
  accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && in_ready && !flush) |=> ((vld & $past(wr_oh)) != '0));
  // R9
  issued_freed_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (iss_valid && !flush) |=> ((vld & $past(grant)) == '0));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush |=> (vld == '0));
endmodule

bind rs_sched rs_sched_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
  .iss_valid(iss_valid), .vld(vld), .rdy_vec(rdy_vec), .grant(grant), .wr_oh(wr_oh)
);

// File: tb/sim_rs_sched.sv
`timescale 1ns/1ps
module sim_rs_sched;
  localparam int DEPTH = 8;
  localparam int TAG_W = 6;
  localparam int PAY_W = 16;

  logic             clk, rst_n, flush, in_valid, in_ready;
  logic [TAG_W-1:0] in_src1_tag, in_src2_tag, in_dst_tag, wb_tag;
  logic             in_src1_rdy, in_src2_rdy, wb_valid;
  logic [PAY_W-1:0] in_payload;
  logic             iss_valid;
  logic [TAG_W-1:0] iss_dst_tag;
  logic [PAY_W-1:0] iss_payload;

  rs_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PAY_W(PAY_W)) u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int seq_ctr = 0;
  int pay_ctr = 1;
  bit done = 0;

  // reference model
  bit         m_v  [DEPTH];
  int         m_seq[DEPTH];
  int         m_t1 [DEPTH], m_t2[DEPTH], m_dst[DEPTH], m_pay[DEPTH];
  bit         m_r1 [DEPTH], m_r2[DEPTH];

  function automatic int model_count();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) c += m_v[i];
    return c;
  endfunction

  function automatic int model_pick();
    int p = -1;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_r1[i] && m_r2[i] && (p < 0 || m_seq[i] < m_seq[p])) p = i;
    return p;
  endfunction

  function automatic void model_update(int p);
    bit acc;
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
      return;
    end
    acc = in_valid && (model_count() < DEPTH);
    if (p >= 0) m_v[p] = 0;
    for (int i = 0; i < DEPTH; i++) if (m_v[i] && wb_valid) begin
      if (m_t1[i] == int'(wb_tag)) m_r1[i] = 1;
      if (m_t2[i] == int'(wb_tag)) m_r2[i] = 1;
    end
    if (acc) begin
      for (int i = 0; i < DEPTH; i++) if (!m_v[i]) begin
        m_v[i] = 1; m_seq[i] = seq_ctr; seq_ctr++;
        m_t1[i] = int'(in_src1_tag); m_t2[i] = int'(in_src2_tag);
        m_r1[i] = in_src1_rdy || (wb_valid && in_src1_tag == wb_tag);
        m_r2[i] = in_src2_rdy || (wb_valid && in_src2_tag == wb_tag);
        m_dst[i] = int'(in_dst_tag); m_pay[i] = int'(in_payload);
        break;
      end
    end
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input string req);
    int p = model_pick();
    chk(req, "in_ready", int'(in_ready), int'(model_count() < DEPTH));
    chk(req, "iss_valid", int'(iss_valid), int'(p >= 0));
    if (p >= 0 && iss_valid) begin
      chk(req, "iss_payload", int'(iss_payload), m_pay[p]);
      chk(req, "iss_dst_tag", int'(iss_dst_tag), m_dst[p]);
    end
    model_update(p);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(input bit v, input int t1, input bit r1, input int t2, input bit r2);
    in_valid = v; in_src1_tag = TAG_W'(t1); in_src1_rdy = r1;
    in_src2_tag = TAG_W'(t2); in_src2_rdy = r2;
    in_dst_tag = TAG_W'(pay_ctr % 64); in_payload = PAY_W'(pay_ctr); pay_ctr++;
  endtask

  task automatic idle();
    in_valid = 0; wb_valid = 0; flush = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    rst_n = 0; idle(); offer(0, 0, 0, 0, 0); wb_tag = '0;
    repeat (3) @(negedge clk);
    // R1: state held at reset
    chk("R1", "iss_valid in reset", int'(iss_valid), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1;
    repeat (3) step("R1");

    // R2 / R4: ready micro-ops stream through in order
    for (int k = 0; k < 3; k++) begin offer(1, 1, 1, 2, 1); step("R2"); end
    idle(); repeat (3) step("R4");

    // R5: blocked oldest skipped; R7: broadcast wakes it
    offer(1, 5, 0, 2, 1); step("R5");
    offer(1, 1, 1, 2, 1); step("R5");
    offer(1, 3, 1, 4, 1); step("R5");
    idle(); repeat (2) step("R6");
    chk("R5", "blocked entry still held", int'(model_count()), 1);
    wb_valid = 1; wb_tag = 6'd5; step("R7");
    idle(); step("R7"); step("R6");

    // R8: source matched by broadcast in arrival cycle
    offer(1, 9, 0, 2, 1); wb_valid = 1; wb_tag = 6'd9; step("R8");
    idle(); step("R8"); step("R6");

    // R3 / R9: fill behind tag 20, offer while full, then drain
    for (int k = 0; k < DEPTH; k++) begin offer(1, 20, 0, 2, 1); step("R3"); end
    offer(1, 1, 1, 2, 1); step("R3");
    chk("R3", "in_ready when full", int'(in_ready), 0);
    idle(); wb_valid = 1; wb_tag = 6'd20; step("R9");
    idle(); step("R9");
    chk("R9", "in_ready after one issue", int'(in_ready), 1);
    repeat (DEPTH + 1) step("R4");

    // R10: flush drops queue and concurrent offer
    for (int k = 0; k < 4; k++) begin offer(1, 30, 0, 31, 1); step("R10"); end
    offer(1, 1, 1, 2, 1); flush = 1; step("R10");
    idle();
    chk("R10", "in_ready after flush", int'(in_ready), 1);
    chk("R10", "iss_valid after flush", int'(iss_valid), 0);
    wb_valid = 1; wb_tag = 6'd30; step("R10");
    idle(); repeat (2) step("R10");

    // random mix: R2 R4 R5 R6 R7 R8 R11
    for (int c = 0; c < 6000; c++) begin
      offer(($urandom % 4) != 0, $urandom % 12, ($urandom % 3) == 0,
            $urandom % 12, ($urandom % 2) == 0);
      wb_valid = ($urandom % 3) == 0;
      wb_tag   = TAG_W'($urandom % 12);
      flush    = ($urandom % 400) == 0;
      step("R11");
    end
    idle();
    repeat (20) begin wb_valid = 1; wb_tag = TAG_W'($urandom % 12); step("R4"); end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule